// File: doc/BRIEF.md
# Phase-Frequency Detector with Powerdown Sequencing

This block compares two divided pulse streams, one derived from the reference and one from the VCO. It turns their timing difference into charge-pump raise and lower commands. Each stream arrives as single-cycle pulses on the block clock. A raise/lower flag pair is set by the pulses and cleared together after both flags have been high for a fixed minimum width. Because of this, both commands pulse even when the two edges coincide, and the detector has no dead zone. The linear range covers one full period of error in either direction.

A polarity input picks which flag drives which command, so the same loop can serve a VCO with a positive or a negative tuning slope. A tri-state input parks the charge pump in high impedance while the loop keeps running. A powerdown input shuts the loop down and tells the dividers to hold their loaded values. With tri-state low, this shutdown is synchronous: it waits until the pending comparison has drained, so a half-finished correction is never cut off and the VCO does not jump. With tri-state high, the shutdown is immediate. A current-select input is passed on as the high/low charge-pump current level, where low means a quarter of high. A lock monitor counts consecutive clean comparisons and reports lock.

Top module: `pfd_pwr_top`

## Requirements
- R1: When the two pulses arrive in the same cycle, both up and down go high one cycle later and stay high for exactly RST_W cycles (default 2). up and down are never high together for more than RST_W cycles.
- R2: With pol_pos=1, a reference pulse leading the VCO pulse by d cycles gives up high for d+RST_W cycles and down high for RST_W cycles. A VCO pulse leading by d gives down high for d+RST_W cycles and up high for RST_W cycles.
- R3: With pol_pos=0, the roles of up and down in R2 are exchanged.
- R4: When cp_hiz is 1, up and down are both 0. cp_hiz is 1 whenever cp_tri=1. With cp_tri=1 and pwr_down=0, cnt_hold stays 0 and the detector and lock monitor keep running.
- R5: With pwr_down=1 and cp_tri=0, the block keeps driving up/down and keeps cnt_hold=0 until both detector flags are clear. On the edge after that, it sets cnt_hold=1 and cp_hiz=1. cnt_hold=1 always implies cp_hiz=1.
- R6: With pwr_down=1 and cp_tri=1, cnt_hold and cp_hiz are 1 from the cycle after that input is sampled, even with a comparison pending.
- R7: Sampling pwr_down=0 clears cnt_hold on the next cycle. Pulses that arrive during powerdown are discarded, so the detector wakes with both flags clear.
- R8: icp_high equals cur_sel (1 = high current, 0 = quarter current).
- R9: lock_det rises after LOCK_CNT (default 4) consecutive completed comparisons whose error (cycles with exactly one flag high) is at most ERR_MAX (default 1). While locked, lock_det drops low only during the cycles in which both flags are high.
- R10: A single completed comparison with error above ERR_MAX clears lock_det and restarts the count. Powerdown also clears lock_det.
- R11: During reset, up, down, lock_det and cnt_hold are 0, and the block leaves reset in the active, unlocked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_pulse | input | 1 | Divided reference pulse, one cycle wide |
| fp_pulse | input | 1 | Divided VCO pulse, one cycle wide |
| pol_pos | input | 1 | 1 = positive tuning slope, 0 = negative |
| cp_tri | input | 1 | Request charge-pump high impedance |
| cur_sel | input | 1 | Charge-pump current level request |
| pwr_down | input | 1 | Powerdown request |
| up | output | 1 | Charge-pump raise command |
| down | output | 1 | Charge-pump lower command |
| cp_hiz | output | 1 | Charge pump in high impedance |
| icp_high | output | 1 | Charge pump at full current |
| lock_det | output | 1 | Lock indication, low during flag overlap |
| cnt_hold | output | 1 | Dividers must hold their loaded values |

## Verification
The bench drives coincident pulses and pulses with a lead on each side under both polarities, and counts how many cycles up and down stay high. A swapped polarity mux or a wrong reset width shows up directly in those counts. For synchronous powerdown, pwr_down is raised while a comparison is still open. The bench checks that up keeps driving and cnt_hold stays low until the comparison closes; a design that shut down at once would truncate the correction. For wake-up, a pulse is sent during powerdown. The bench then confirms that the detector does not later pair it with a fresh pulse, which a design that kept its flags through powerdown would do. For lock, the bench walks the clean-comparison count exactly to its boundary, checks that an error equal to the threshold is tolerated and that one cycle more drops lock, and checks that the narrow low dip appears during overlap.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_DRAIN = 2'd1,
        PM_OFF   = 2'd2
    } pm_state_e;

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
    parameter int RST_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fr_pulse,
    input  logic fp_pulse,
    input  logic flush,
    output logic ref_flag,
    output logic vco_flag,
    output logic cmp_done,
    output logic err_tick
);
    localparam int RCW = $clog2(RST_W) + 1;

    typedef struct packed {
        logic           ref_f;
        logic           vco_f;
        logic [RCW-1:0] rcnt;
    } core_t;

    core_t s_d, s_q;
    logic  both;

    always_comb begin
        both     = s_q.ref_f & s_q.vco_f;
        cmp_done = both && (s_q.rcnt == RCW'(RST_W - 1));
        err_tick = s_q.ref_f ^ s_q.vco_f;
        s_d      = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            s_d.ref_f = (s_q.ref_f & ~cmp_done) | fr_pulse;
            s_d.vco_f = (s_q.vco_f & ~cmp_done) | fp_pulse;
            s_d.rcnt  = (!both || cmp_done) ? '0 : s_q.rcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ref_flag = s_q.ref_f;
    assign vco_flag = s_q.vco_f;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int ERR_MAX  = 1,
    parameter int LOCK_CNT = 4,
    parameter int ERR_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic err_tick,
    input  logic cmp_done,
    output logic locked
);
    localparam int GW = $clog2(LOCK_CNT + 1);

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [GW-1:0]    good;
        logic             lock;
    } lock_t;

    lock_t s_d, s_q;
    logic  clean;

    always_comb begin
        clean = (s_q.err <= ERR_W'(ERR_MAX));
        s_d   = s_q;
        if (flush) begin
            s_d = '0;
        end else if (cmp_done) begin
            s_d.err = '0;
            if (clean) begin
                s_d.good = (s_q.good == GW'(LOCK_CNT)) ? s_q.good : s_q.good + 1'b1;
                s_d.lock = (s_d.good == GW'(LOCK_CNT));
            end else begin
                s_d.good = '0;
                s_d.lock = 1'b0;
            end
        end else if (err_tick && (s_q.err != '1)) begin
            s_d.err = s_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign locked = s_q.lock;
endmodule

// File: rtl/pfd_pwr_seq.sv
module pfd_pwr_seq
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_down,
    input  logic      cp_tri,
    input  logic      pfd_idle,
    output pm_state_e state,
    output logic      going_off
);
    typedef struct packed {
        pm_state_e st;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!pwr_down)                   s_d.st = PM_RUN;
        else if (cp_tri)                 s_d.st = PM_OFF;
        else if (s_q.st == PM_OFF)       s_d.st = PM_OFF;
        else if (pfd_idle)               s_d.st = PM_OFF;
        else                             s_d.st = PM_DRAIN;
        going_off = (s_d.st == PM_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: PM_RUN};
        else        s_q <= s_d;
    end

    assign state = s_q.st;
endmodule

// File: rtl/pfd_pwr_top.sv
module pfd_pwr_top
    import pfd_pkg::*;
#(
    parameter int RST_W    = 2,
    parameter int ERR_MAX  = 1,
    parameter int LOCK_CNT = 4,
    parameter int ERR_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fr_pulse,
    input  logic fp_pulse,
    input  logic pol_pos,
    input  logic cp_tri,
    input  logic cur_sel,
    input  logic pwr_down,
    output logic up,
    output logic down,
    output logic cp_hiz,
    output logic icp_high,
    output logic lock_det,
    output logic cnt_hold
);
    logic      ref_flag, vco_flag, cmp_done, err_tick;
    logic      going_off, locked;
    pm_state_e pm_st;

    pfd_core #(.RST_W(RST_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .fr_pulse (fr_pulse),
        .fp_pulse (fp_pulse),
        .flush    (going_off),
        .ref_flag (ref_flag),
        .vco_flag (vco_flag),
        .cmp_done (cmp_done),
        .err_tick (err_tick)
    );

    pfd_lock_mon #(.ERR_MAX(ERR_MAX), .LOCK_CNT(LOCK_CNT), .ERR_W(ERR_W)) i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (going_off),
        .err_tick (err_tick),
        .cmp_done (cmp_done),
        .locked   (locked)
    );

    pfd_pwr_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .cp_tri    (cp_tri),
        .pfd_idle  (!ref_flag && !vco_flag),
        .state     (pm_st),
        .going_off (going_off)
    );

    always_comb begin
        cnt_hold = (pm_st == PM_OFF);
        cp_hiz   = cp_tri | cnt_hold;
        up       = !cp_hiz && (pol_pos ? ref_flag : vco_flag);
        down     = !cp_hiz && (pol_pos ? vco_flag : ref_flag);
        icp_high = cur_sel;
        lock_det = locked && !(ref_flag && vco_flag);
    end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int RST_W = 2
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic cp_tri,
    input logic up,
    input logic down,
    input logic cp_hiz,
    input logic cnt_hold,
    input logic lock_det
);
    logic [7:0] ovl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    ovl_q <= '0;
        else if (!(up && down))        ovl_q <= '0;
        else if (ovl_q != 8'hFF)       ovl_q <= ovl_q + 1'b1;
    end

    AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_q <= 8'(RST_W)) else $error("overlap too long"); // R1
    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cp_hiz |-> (!up && !down)) else $error("drive while hiz"); // R4
    AST_TRI_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cp_tri |-> cp_hiz) else $error("tri not honoured"); // R4
    AST_HOLD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hold |-> cp_hiz) else $error("hold without hiz"); // R5
    AST_ASYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && cp_tri) |=> cnt_hold) else $error("async off late"); // R6
    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down |=> !cnt_hold) else $error("wake late"); // R7
    AST_OFF_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hold |-> !lock_det) else $error("lock in powerdown"); // R10
endmodule

bind pfd_pwr_top pfd_checker #(.RST_W(RST_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .cp_tri   (cp_tri),
    .up       (up),
    .down     (down),
    .cp_hiz   (cp_hiz),
    .cnt_hold (cnt_hold),
    .lock_det (lock_det)
);

// File: tb/test_pfd_pwr_top.sv
module test_pfd_pwr_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fr_pulse = 1'b0, fp_pulse = 1'b0, pol_pos = 1'b1;
    logic cp_tri = 1'b0, cur_sel = 1'b0, pwr_down = 1'b0;
    logic up, down, cp_hiz, icp_high, lock_det, cnt_hold;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pfd_pwr_top i_pfd_pwr_top (
        .clk(clk), .rst_n(rst_n), .fr_pulse(fr_pulse), .fp_pulse(fp_pulse),
        .pol_pos(pol_pos), .cp_tri(cp_tri), .cur_sel(cur_sel), .pwr_down(pwr_down),
        .up(up), .down(down), .cp_hiz(cp_hiz), .icp_high(icp_high),
        .lock_det(lock_det), .cnt_hold(cnt_hold)
    );

    typedef struct packed {
        logic       pol;
        logic [3:0] dfr;
        logic [3:0] dfp;
        logic [3:0] eup;
        logic [3:0] edn;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 4'd0, 4'd0, 4'd2, 4'd2},
        '{1'b1, 4'd0, 4'd3, 4'd5, 4'd2},
        '{1'b1, 4'd2, 4'd0, 4'd2, 4'd4},
        '{1'b0, 4'd0, 4'd3, 4'd2, 4'd5},
        '{1'b0, 4'd1, 4'd0, 4'd3, 4'd2},
        '{1'b1, 4'd0, 4'd1, 4'd3, 4'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic compare(input int dfr, input int dfp, output int nup, output int ndn);
        nup = 0;
        ndn = 0;
        for (int c = 0; c < 14; c++) begin
            cyc();
            if (up) nup++;
            if (down) ndn++;
            fr_pulse = (c == dfr);
            fp_pulse = (c == dfp);
        end
        fr_pulse = 1'b0;
        fp_pulse = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int nu, nd;
        repeat (3) cyc();
        // R11 reset state
        check("R11 up", up, 0);
        check("R11 down", down, 0);
        check("R11 lock_det", lock_det, 0);
        check("R11 cnt_hold", cnt_hold, 0);
        rst_n = 1'b1;
        cyc();
        check("R11 cp_hiz after reset", cp_hiz, 0);

        // R1 R2 R3: vector table
        foreach (VEC[i]) begin
            pol_pos = VEC[i].pol;
            compare(int'(VEC[i].dfr), int'(VEC[i].dfp), nu, nd);
            if (VEC[i].pol) begin
                check("R2 up width", nu, int'(VEC[i].eup));
                check("R2 down width", nd, int'(VEC[i].edn));
            end else begin
                check("R3 up width", nu, int'(VEC[i].eup));
                check("R3 down width", nd, int'(VEC[i].edn));
            end
        end
        pol_pos = 1'b1;

        // R8 current select
        cur_sel = 1'b1; #1;
        check("R8 icp_high high", icp_high, 1);
        cur_sel = 1'b0; #1;
        check("R8 icp_high low", icp_high, 0);

        // R10: bad comparison restarts count, then R9 boundary
        compare(0, 5, nu, nd);
        check("R10 unlocked after bad", lock_det, 0);
        for (int k = 0; k < 3; k++) compare(0, 0, nu, nd);
        check("R9 not locked after LOCK_CNT-1", lock_det, 0);
        compare(0, 0, nu, nd);
        check("R9 locked after LOCK_CNT", lock_det, 1);
        // R9 narrow low during overlap
        cyc();
        fr_pulse = 1'b1; fp_pulse = 1'b1;
        cyc();
        fr_pulse = 1'b0; fp_pulse = 1'b0;
        check("R9 lock_det low in overlap", lock_det, 0);
        repeat (3) cyc();
        check("R9 lock_det back high", lock_det, 1);
        compare(0, 1, nu, nd);
        check("R9 error at threshold keeps lock", lock_det, 1);
        compare(0, 2, nu, nd);
        check("R10 error above threshold drops lock", lock_det, 0);

        // R4 tri-state, loop keeps running
        cp_tri = 1'b1;
        compare(0, 3, nu, nd);
        check("R4 up quiet", nu, 0);
        check("R4 down quiet", nd, 0);
        check("R4 cp_hiz", cp_hiz, 1);
        check("R4 cnt_hold", cnt_hold, 0);
        for (int k = 0; k < 4; k++) compare(0, 0, nu, nd);
        check("R4 lock tracked under tri", lock_det, 1);
        cp_tri = 1'b0;
        cyc();

        // R5 synchronous powerdown waits for drain
        fr_pulse = 1'b1;
        cyc();
        fr_pulse = 1'b0;
        pwr_down = 1'b1;
        cyc();
        check("R5 still driving up", up, 1);
        check("R5 hold deferred", cnt_hold, 0);
        fp_pulse = 1'b1;
        cyc();
        fp_pulse = 1'b0;
        check("R5 hold deferred in overlap", cnt_hold, 0);
        repeat (4) cyc();
        check("R5 hold after drain", cnt_hold, 1);
        check("R5 hiz after drain", cp_hiz, 1);
        check("R10 lock cleared by powerdown", lock_det, 0);

        // R7 wake drops pulses seen in powerdown
        fr_pulse = 1'b1;
        cyc();
        fr_pulse = 1'b0;
        cyc();
        pwr_down = 1'b0;
        cyc();
        check("R7 hold released", cnt_hold, 0);
        check("R7 hiz released", cp_hiz, 0);
        fp_pulse = 1'b1;
        cyc();
        fp_pulse = 1'b0;
        repeat (3) cyc();
        check("R7 stale ref dropped down", down, 1);
        check("R7 stale ref dropped up", up, 0);
        fr_pulse = 1'b1;
        cyc();
        fr_pulse = 1'b0;
        repeat (4) cyc();
        check("R7 comparison closed", down, 0);

        // R6 asynchronous powerdown immediate
        fr_pulse = 1'b1;
        cyc();
        fr_pulse = 1'b0;
        pwr_down = 1'b1;
        cp_tri   = 1'b1;
        cyc();
        check("R6 hold immediate", cnt_hold, 1);
        check("R6 up quiet", up, 0);
        pwr_down = 1'b0;
        cp_tri   = 1'b0;
        cyc();
        check("R6 R7 wake", cnt_hold, 0);
        check("R6 pending flag discarded", up, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule